// File: doc/BRIEF.md
# Condition Code Flag Generator

This block produces the four arithmetic condition flags (negative, zero, overflow, carry) of an 8-bit accumulator machine. That machine can also pair its two 8-bit accumulators into a single 16-bit register. Each cycle the surrounding datapath can present an operation class, a width select, the two operands, the finished result and the current flag byte. For a shift, it also presents the carry bit that the shifter pushed out. One clock later the block returns the new flag byte.

The four flags sit at fixed positions in the flag byte, because instruction decode elsewhere reads them there. All other bits of the byte pass through unchanged. The block has no state machine. Its only state is one output register stage with two steady conditions: holding, and loading on a valid input. Its only transition is "load", taken on any cycle where `op_valid` is high.

Top module: `ccf_flag_gen`

## Requirements
- R1: For class ADD (`op_class` = 2'b00), C is the top bit of (a AND b) OR (b AND NOT r) OR (a AND NOT r).
- R2: For class ADD, V is the top bit of (a AND b AND NOT r) OR (NOT a AND NOT b AND r).
- R3: For class SUB (`op_class` = 2'b01), C is the top bit of (NOT a AND b) OR (b AND r) OR (NOT a AND r), and V is the top bit of (a AND NOT b AND NOT r) OR (NOT a AND b AND r).
- R4: For every class, N equals the top bit of r and Z is 1 exactly when the active-width part of r is zero.
- R5: For class TEST (`op_class` = 2'b10), V is cleared and C keeps its incoming value.
- R6: For class SHIFT (`op_class` = 2'b11), C takes `shift_c`, and V equals the new N XOR the new C.
- R7: With `wide` = 0 the top bit is bit 7 and bits 15:8 of a, b and r are ignored. With `wide` = 1 the top bit is bit 15, and the 16-bit value holds accumulator A in bits 15:8 and accumulator B in bits 7:0.
- R8: In the flag byte, C is bit 0, V is bit 1, Z is bit 2 and N is bit 3. Bits 7:4 of `flags_out` copy bits 7:4 of `flags_in`.
- R9: The flag byte and `out_valid` change one clock after an input with `op_valid` = 1. `flags_out` holds its value on cycles after `op_valid` = 0.
- R10: Reset (`rst_n` low) clears `flags_out` to 8'h00 and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Inputs are valid this cycle |
| op_class | input | 2 | 00 add, 01 subtract, 10 test, 11 shift |
| wide | input | 1 | 0: 8-bit operation, 1: 16-bit operation |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | input | 16 | Datapath result |
| shift_c | input | 1 | Carry out of the shifter |
| flags_in | input | 8 | Current flag byte |
| flags_out | output | 8 | Updated flag byte |
| out_valid | output | 1 | flags_out was loaded on the last edge |

## Verification
The assertions take for granted that the operation class and width are known values whenever `op_valid` is high. They also take for granted that `result` is whatever the datapath produced: the equations are checked against the given result, and the result is never checked against the operands. The stimulus therefore drives consistent operand and result triples, each computed as a real sum, difference or shift. It fills the unused upper bytes in narrow mode with unrelated patterns, which shows that they are ignored. Between loads, the inputs are changed while `op_valid` is held low.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_TEST  = 2'b10,
        CLS_SHIFT = 2'b11
    } op_cls_t;

    // flag positions decoded by branch logic elsewhere
    localparam int FLG_C = 0;
    localparam int FLG_V = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;
    localparam int FLG_KEEP_LO = 4;
endpackage

// File: rtl/ccf_arith.sv
// Carry and overflow for add/subtract at one width.
module ccf_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic         is_sub,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] c_vec;
    logic [W-1:0] v_vec;

    always_comb begin
        if (is_sub) begin
            c_vec = (b & r) | (~a & r) | (~a & b);
            v_vec = (~a & b & r) | (a & ~b & ~r);
        end else begin
            c_vec = (a & ~r) | (b & ~r) | (a & b);
            v_vec = (~a & ~b & r) | (a & b & ~r);
        end
        carry = c_vec[W-1];
        ovf   = v_vec[W-1];
    end
endmodule

// File: rtl/ccf_result.sv
// Sign and zero detection of the result at one width.
module ccf_result #(
    parameter int W = 8
) (
    input  logic [W-1:0] r,
    output logic         neg,
    output logic         zero
);
    assign neg  = r[W-1];
    assign zero = ~|r;
endmodule

// File: rtl/ccf_flag_gen.sv
module ccf_flag_gen #(
    parameter int DW = 16,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_class,
    input  logic          wide,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] result,
    input  logic          shift_c,
    input  logic [FW-1:0] flags_in,
    output logic [FW-1:0] flags_out,
    output logic          out_valid
);
    import ccf_pkg::*;

    localparam int HW     = DW / 2;
    localparam int NLANES = 2;

    logic [NLANES-1:0] lane_c, lane_v, lane_n, lane_z;
    op_cls_t           cls;
    logic              sel_c, sel_v, sel_n, sel_z;
    logic [FW-1:0]     nxt;

    assign cls = op_cls_t'(op_class);

    // lane 0 narrow (low half), lane 1 full width
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? HW : DW;
        ccf_arith #(.W(LW)) u_arith (
            .a      (opnd_a[LW-1:0]),
            .b      (opnd_b[LW-1:0]),
            .r      (result[LW-1:0]),
            .is_sub (cls == CLS_SUB),
            .carry  (lane_c[g]),
            .ovf    (lane_v[g])
        );
        ccf_result #(.W(LW)) u_res (
            .r    (result[LW-1:0]),
            .neg  (lane_n[g]),
            .zero (lane_z[g])
        );
    end

    assign sel_c = wide ? lane_c[1] : lane_c[0];
    assign sel_v = wide ? lane_v[1] : lane_v[0];
    assign sel_n = wide ? lane_n[1] : lane_n[0];
    assign sel_z = wide ? lane_z[1] : lane_z[0];

    always_comb begin
        nxt        = flags_in;
        nxt[FLG_N] = sel_n;
        nxt[FLG_Z] = sel_z;
        unique case (cls)
            CLS_ADD, CLS_SUB: begin
                nxt[FLG_C] = sel_c;
                nxt[FLG_V] = sel_v;
            end
            CLS_TEST: begin
                nxt[FLG_V] = 1'b0;
            end
            CLS_SHIFT: begin
                nxt[FLG_C] = shift_c;
                nxt[FLG_V] = sel_n ^ shift_c;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_out <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= op_valid;
            if (op_valid) flags_out <= nxt;
        end
    end

    // ---------------- assertions ----------------
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> out_valid);

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_out));

    p_upper_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flags_out[FW-1:FLG_KEEP_LO] == $past(flags_in[FW-1:FLG_KEEP_LO]));

    p_test_clears_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 2'b10) |=>
            (!flags_out[FLG_V] && flags_out[FLG_C] == $past(flags_in[FLG_C])));

    p_shift_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 2'b11) |=>
            (flags_out[FLG_C] == $past(shift_c) &&
             flags_out[FLG_V] == (flags_out[FLG_N] ^ flags_out[FLG_C])));

    p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flags_out[FLG_N] ==
            ($past(wide) ? $past(result[DW-1]) : $past(result[HW-1])));

    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wide) |=> flags_out[FLG_Z] == ($past(result) == '0));
endmodule

// File: tb/tb_ccf_flag_gen.sv
module tb_ccf_flag_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_class = 2'b00;
    logic        wide = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, result = '0;
    logic        shift_c = 1'b0;
    logic [7:0]  flags_in = '0;
    logic [7:0]  flags_out;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ccf_flag_gen dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .wide(wide), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .shift_c(shift_c), .flags_in(flags_in),
        .flags_out(flags_out), .out_valid(out_valid)
    );

    // vector: class(2) wide(1) a(16) b(16) r(16) shift_c(1) flags_in(8) = 60 bits
    localparam int NV = 16;
    localparam logic [59:0] VEC [NV] = '{
        {2'b00, 1'b0, 16'h007F, 16'h0001, 16'h0080, 1'b0, 8'hA0}, // add: V, N
        {2'b00, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 8'h5F}, // add: C, Z
        {2'b00, 1'b1, 16'h8000, 16'h8000, 16'h0000, 1'b0, 8'h00}, // add16: C V Z
        {2'b00, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 8'hF0}, // add16: V N
        {2'b00, 1'b0, 16'hAB3C, 16'h5D41, 16'h997D, 1'b0, 8'h0F}, // add8, junk upper
        {2'b01, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b0, 8'h00}, // sub: borrow, N
        {2'b01, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, 8'hC0}, // sub: V
        {2'b01, 1'b1, 16'h1234, 16'h1234, 16'h0000, 1'b0, 8'h0F}, // sub16: Z
        {2'b01, 1'b1, 16'h0100, 16'h0200, 16'hFF00, 1'b0, 8'h30}, // sub16: C N
        {2'b10, 1'b0, 16'hFF00, 16'h0000, 16'h7700, 1'b0, 8'h03}, // test8 zero, C kept
        {2'b10, 1'b1, 16'h0000, 16'h0000, 16'h8000, 1'b0, 8'h0A}, // test16 neg, V cleared
        {2'b11, 1'b0, 16'h0000, 16'h0000, 16'h0080, 1'b1, 8'h00}, // shift N=1 C=1 V=0
        {2'b11, 1'b0, 16'h0000, 16'h0000, 16'h0001, 1'b1, 8'h9A}, // shift V=1
        {2'b11, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1, 8'h00}, // shift16 Z, V
        {2'b11, 1'b1, 16'h0000, 16'h0000, 16'hC000, 1'b0, 8'h0F}, // shift16 N, V
        {2'b01, 1'b0, 16'h5500, 16'h9900, 16'h1200, 1'b0, 8'h66}  // sub8 of zeros, upper junk
    };

    function automatic logic [7:0] model(input logic [1:0] c, input logic w,
            input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
            input logic sc, input logic [7:0] fi);
        logic [7:0] f;
        int t;
        logic nn, zz, cc, vv;
        logic [15:0] m;
        t  = w ? 15 : 7;
        m  = w ? 16'hFFFF : 16'h00FF;
        nn = r[t];
        zz = ((r & m) == 16'h0000);
        f  = fi;
        f[3] = nn;
        f[2] = zz;
        case (c)
            2'b00: begin
                cc = (a[t] & b[t]) | (b[t] & ~r[t]) | (a[t] & ~r[t]);
                vv = (a[t] & b[t] & ~r[t]) | (~a[t] & ~b[t] & r[t]);
                f[0] = cc; f[1] = vv;
            end
            2'b01: begin
                cc = (~a[t] & b[t]) | (b[t] & r[t]) | (~a[t] & r[t]);
                vv = (a[t] & ~b[t] & ~r[t]) | (~a[t] & b[t] & r[t]);
                f[0] = cc; f[1] = vv;
            end
            2'b10: f[1] = 1'b0;
            default: begin
                f[0] = sc; f[1] = nn ^ sc;
            end
        endcase
        return f;
    endfunction

    function automatic string tag_of(input logic [1:0] c);
        case (c)
            2'b00:   return "R1 R2 R4 R7 R8";
            2'b01:   return "R3 R4 R7 R8";
            2'b10:   return "R5 R4 R7 R8";
            default: return "R6 R4 R7 R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [59:0] v);
        @(negedge clk);
        op_class = v[59:58]; wide = v[57];
        opnd_a = v[56:41]; opnd_b = v[40:25]; result = v[24:9];
        shift_c = v[8]; flags_in = v[7:0];
        op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] held;
        logic [7:0] e;
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 flags", flags_out, 8'h00);
        check("R10 valid", {7'b0, out_valid}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            load(VEC[i]);
            e = model(VEC[i][59:58], VEC[i][57], VEC[i][56:41], VEC[i][40:25],
                      VEC[i][24:9], VEC[i][8], VEC[i][7:0]);
            check(tag_of(VEC[i][59:58]), flags_out, e);
            check("R9 out_valid", {7'b0, out_valid}, 8'h01);
        end

        // directed hand values: R1 R2 8-bit 0x7F+1 -> N V, upper from A0
        load({2'b00, 1'b0, 16'h007F, 16'h0001, 16'h0080, 1'b0, 8'hA0});
        check("R2 add overflow", flags_out, 8'hAA);
        // R1 0xFF+1 -> C Z
        load({2'b00, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 8'h00});
        check("R1 add carry", flags_out, 8'h05);
        // R3 0-1 -> N C
        load({2'b01, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b0, 8'h00});
        check("R3 sub borrow", flags_out, 8'h09);
        // R7: same low bytes but wide -> bit 15 decides: 0x00FF result not negative
        load({2'b01, 1'b1, 16'h0100, 16'h0001, 16'h00FF, 1'b0, 8'h00});
        check("R7 wide top bit", flags_out, 8'h00);
        // R7: narrow, upper bytes nonzero but low byte zero -> Z set
        load({2'b10, 1'b0, 16'hFFFF, 16'hFFFF, 16'h8000, 1'b0, 8'h00});
        check("R7 narrow ignores upper", flags_out, 8'h04);
        // R5: test keeps C=1, clears V
        load({2'b10, 1'b1, 16'h0000, 16'h0000, 16'h0001, 1'b0, 8'h03});
        check("R5 test", flags_out, 8'h01);
        // R6: shift N=1 C=0 -> V=1
        load({2'b11, 1'b1, 16'h0000, 16'h0000, 16'h8001, 1'b0, 8'h01});
        check("R6 shift", flags_out, 8'h0A);
        // R8: upper bits copied
        load({2'b10, 1'b0, 16'h0000, 16'h0000, 16'h0001, 1'b0, 8'h5C});
        check("R8 passthrough", flags_out, 8'h50);

        // R9: idle cycles with changed inputs leave flags held
        held = flags_out;
        @(negedge clk);
        op_class = 2'b00; wide = 1'b0; opnd_a = 16'h00FF; opnd_b = 16'h0001;
        result = 16'h0000; flags_in = 8'hFF;
        repeat (3) @(negedge clk);
        check("R9 hold", flags_out, held);
        check("R9 valid low", {7'b0, out_valid}, 8'h00);

        // R10: reset again after activity
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 re-reset", flags_out, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule